// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Zero Bus Turnaround

This block is a synthesizable model of a flow-through synchronous SRAM. Its data bus can be kept busy on every clock, whatever the mix of reads and writes. A cycle is opened on a rising edge while the load strobe is low. On that edge the block registers the address, the read/write select, the chip enables and the byte write enables. A read returns its word in the same clock period, straight from the array, with no output register in the path. A write takes its data one edge later. This late write lets a read follow a write, or a write follow a read, with no idle cycle between them.

The late data is held in a pending-write register. That register is copied into the array on the data edge of the next write, or on any edge whose cycle leaves the array free (a deselect cycle). A read whose address matches the pending entry gets the pending bytes laid over the array word, so it always sees the newest contents. A clock enable freezes the whole block. A snooze input turns every new cycle into a deselect and leaves the stored data unchanged. An asynchronous output enable gates the read path onto the bus. The bus is modelled as a data-in port, a data-out port and a drive flag.

Top module: `latewr_sram`

## Requirements
- R1: A cycle opens on an active edge with `ld_n` low. Three chip enable signals are decoded: `cs1_n`, `cs2` and `cs3_n`. The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. When selected, `we_n`=1 gives a read and `we_n`=0 gives a write. Any other chip-enable combination gives a deselect, which writes nothing and leaves the bus undriven.
- R2: The word for a read opened at edge N appears on `dout` with `dout_en`=1 after edge N and before edge N+1, as long as `oe_n` is low.
- R3: A write opened at edge N takes its address and byte enables at edge N and its data from `din` at edge N+1. The value on `din` at edge N is ignored.
- R4: `bwe_n[i]`=0 writes byte lane i, which is bits [8i+7:8i]. Lanes with `bwe_n[i]`=1 keep their old value. An all-ones mask writes nothing.
- R5: Reads and writes run back to back in any order. A read issued on the data edge of a write to the same address returns the merged new bytes.
- R6: An active edge with `ld_n` high repeats the previous cycle type at the previously loaded address and mask. On such an edge the chip enables, `addr` and `bwe_n` are ignored.
- R7: While `cke_n` is high, an edge has no effect. No cycle opens, no write data is taken, and `dout`/`dout_en` hold their values.
- R8: `oe_n` high forces `dout_en`=0 and `dout`=0 at once, without waiting for a clock edge.
- R9: `dout_en` is 0 during the clock period in which a write's data is taken, and during deselect periods.
- R10: While `sleep` is high, each active edge opens a deselect cycle. Stored data is kept.
- R11: Reads or deselect cycles that come between a write and a later read never lose the pending write.
- R12: During and right after reset there is no open cycle and no pending write, and `dout_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_n | input | 1 | Active-low clock enable |
| cs1_n | input | 1 | Active-low chip enable |
| cs2 | input | 1 | Active-high chip enable |
| cs3_n | input | 1 | Active-low chip enable |
| ld_n | input | 1 | Low: open a new cycle; high: repeat the previous one |
| we_n | input | 1 | Read (1) or write (0) select |
| bwe_n | input | NLANE | Active-low byte write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Snooze request |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data (late, one edge after the address) |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Bus drive flag |

## Verification
A wrong pending-write register shows up on the very first read of that address. A stale or half-merged word appears on `dout` in the same clock period that the read opens, or, if the entry is dropped on a deselect, on the first read of that address afterwards. A wrong decoded cycle type shows on `dout_en` one edge after the command. The bench therefore drives every address through every byte mask and every write-then-read ordering. After each edge it compares `dout` and `dout_en` with a word-level model, so a fault is seen in the cycle it first becomes visible.

// File: rtl/latewr_pkg.sv
`timescale 1ns/1ps
package latewr_pkg;
   typedef enum logic [1:0] {
      OP_DES = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2
   } op_e;

   function automatic logic chip_sel(input logic c1n, input logic c2, input logic c3n);
      return !c1n && c2 && !c3n;
   endfunction
endpackage

// File: rtl/latewr_ctrl.sv
`timescale 1ns/1ps
module latewr_ctrl #(
   parameter int ADDR_W = 4,
   parameter int NLANE  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cke_n,
   input  logic                sleep,
   input  logic                ld_n,
   input  logic                we_n,
   input  logic                cs1_n,
   input  logic                cs2,
   input  logic                cs3_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [NLANE-1:0]    bwe_n,
   output latewr_pkg::op_e     op_q,
   output logic [ADDR_W-1:0]   addr_q,
   output logic [NLANE-1:0]    mask_q
);
   import latewr_pkg::*;

   op_e               op_d;
   logic [ADDR_W-1:0] addr_d;
   logic [NLANE-1:0]  mask_d;

   always_comb begin
      op_d   = op_q;
      addr_d = addr_q;
      mask_d = mask_q;
      if (sleep) begin
         op_d = OP_DES;
      end else if (!ld_n) begin
         addr_d = addr;
         mask_d = ~bwe_n;
         if (!chip_sel(cs1_n, cs2, cs3_n)) op_d = OP_DES;
         else if (we_n)                    op_d = OP_RD;
         else                              op_d = OP_WR;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= OP_DES;
         addr_q <= '0;
         mask_q <= '0;
      end else if (!cke_n) begin
         op_q   <= op_d;
         addr_q <= addr_d;
         mask_q <= mask_d;
      end
   end

   p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(op_q) && $stable(addr_q) && $stable(mask_q)));

   p_sleep_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && sleep) |=> (op_q == OP_DES));

   p_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !sleep && ld_n) |=> ($stable(op_q) && $stable(addr_q) && $stable(mask_q)));
endmodule

// File: rtl/latewr_wbuf.sv
`timescale 1ns/1ps
module latewr_wbuf #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16,
   parameter int NLANE  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  latewr_pkg::op_e     op_q,
   input  logic [ADDR_W-1:0]   addr_q,
   input  logic [NLANE-1:0]    mask_q,
   input  logic [DATA_W-1:0]   din,
   output logic                pend_v,
   output logic [ADDR_W-1:0]   pend_addr,
   output logic [NLANE-1:0]    pend_mask,
   output logic [DATA_W-1:0]   pend_data,
   output logic                retire
);
   import latewr_pkg::*;

   // the array port is free on any edge that is not serving a read
   assign retire = adv && pend_v && (op_q != OP_RD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_addr <= '0;
         pend_mask <= '0;
         pend_data <= '0;
      end else if (adv) begin
         if (op_q == OP_WR) begin
            pend_v    <= 1'b1;
            pend_addr <= addr_q;
            pend_mask <= mask_q;
            pend_data <= din;
         end else if (op_q == OP_DES) begin
            pend_v <= 1'b0;
         end
      end
   end

   p_late_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && op_q == OP_WR) |=> (pend_v && pend_data == $past(din)));

   p_pend_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && pend_v && op_q == OP_RD) |=> (pend_v && $stable(pend_data) && $stable(pend_addr)));
endmodule

// File: rtl/latewr_array.sv
`timescale 1ns/1ps
module latewr_array #(
   parameter int ADDR_W = 4,
   parameter int DEPTH  = 16,
   parameter int LANE_W = 8,
   parameter int NLANE  = 2,
   localparam int DATA_W = LANE_W * NLANE
) (
   input  logic                clk,
   input  logic                we,
   input  logic [ADDR_W-1:0]   waddr,
   input  logic [NLANE-1:0]    wmask,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [ADDR_W-1:0]   raddr,
   output logic [DATA_W-1:0]   rdata
);
   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
   end
endmodule

// File: rtl/latewr_sram.sv
`timescale 1ns/1ps
module latewr_sram #(
   parameter  int DATA_W = 16,
   parameter  int LANE_W = 8,
   parameter  int DEPTH  = 16,
   localparam int NLANE  = DATA_W / LANE_W,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              ld_n,
   input  logic              we_n,
   input  logic [NLANE-1:0]  bwe_n,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   import latewr_pkg::*;

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [NLANE-1:0]  mask_q;
   logic              pend_v, retire, hit;
   logic [ADDR_W-1:0] pend_addr;
   logic [NLANE-1:0]  pend_mask;
   logic [DATA_W-1:0] pend_data, arr_q, merged;

   latewr_ctrl #(.ADDR_W(ADDR_W), .NLANE(NLANE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sleep(sleep), .ld_n(ld_n),
      .we_n(we_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .addr(addr),
      .bwe_n(bwe_n), .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q));

   latewr_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NLANE(NLANE)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .adv(!cke_n), .op_q(op_q), .addr_q(addr_q),
      .mask_q(mask_q), .din(din), .pend_v(pend_v), .pend_addr(pend_addr),
      .pend_mask(pend_mask), .pend_data(pend_data), .retire(retire));

   latewr_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LANE_W(LANE_W), .NLANE(NLANE)) u_array (
      .clk(clk), .we(retire), .waddr(pend_addr), .wmask(pend_mask),
      .wdata(pend_data), .raddr(addr_q), .rdata(arr_q));

   assign hit = pend_v && (pend_addr == addr_q);

   for (genvar g = 0; g < NLANE; g++) begin : g_merge
      assign merged[g*LANE_W +: LANE_W] = (hit && pend_mask[g]) ?
         pend_data[g*LANE_W +: LANE_W] : arr_q[g*LANE_W +: LANE_W];
   end

   assign dout_en = (op_q == OP_RD) && !oe_n;
   assign dout    = dout_en ? merged : '0;

   p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !sleep && !ld_n && chip_sel(cs1_n, cs2, cs3_n) && we_n) |=> (oe_n || dout_en));

   p_wrdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !sleep && !ld_n && chip_sel(cs1_n, cs2, cs3_n) && !we_n) |=> !dout_en);

   p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && !chip_sel(cs1_n, cs2, cs3_n)) |=> !dout_en);
endmodule

// File: tb/latewr_sram_bench.sv
`timescale 1ns/1ps
module latewr_sram_bench;
   localparam int DW = 16, LW = 8, DEPTH = 16, AW = 4, NL = 2;
   localparam logic [2:0] SEL = 3'b010; // {cs3_n, cs2, cs1_n}

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke_n = 1'b0, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b0;
   logic ld_n = 1'b0, we_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
   logic [NL-1:0] bwe_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0, dout;
   logic dout_en;

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R12";

   logic [DW-1:0] exp_mem [DEPTH];
   logic [1:0]    m_op = 2'd0;   // 0 deselect, 1 read, 2 write
   logic [AW-1:0] m_addr = '0;
   logic [NL-1:0] m_mask = '0;

   always #2.5 clk = ~clk;

   latewr_sram #(.DATA_W(DW), .LANE_W(LW), .DEPTH(DEPTH)) u_latewr_sram (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
      .cs3_n(cs3_n), .ld_n(ld_n), .we_n(we_n), .bwe_n(bwe_n), .oe_n(oe_n),
      .sleep(sleep), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

   task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual en/data %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_out();
      logic en;
      en = (m_op == 2'd1) && !oe_n;
      check(cur_req, {dout_en, dout}, {en, en ? exp_mem[m_addr] : {DW{1'b0}}});
   endtask

   task automatic go(input logic ckn, input logic sl, input logic ldn, input logic wen,
                     input logic [2:0] cs, input logic [AW-1:0] a,
                     input logic [NL-1:0] bwn, input logic [DW-1:0] d);
      @(negedge clk);
      cke_n = ckn; sleep = sl; ld_n = ldn; we_n = wen;
      cs1_n = cs[0]; cs2 = cs[1]; cs3_n = cs[2];
      addr = a; bwe_n = bwn; din = d;
      @(posedge clk);
      #1;
      if (!ckn) begin
         if (m_op == 2'd2)
            for (int l = 0; l < NL; l++)
               if (m_mask[l]) exp_mem[m_addr][l*LW +: LW] = d[l*LW +: LW];
         if (sl) m_op = 2'd0;
         else if (!ldn) begin
            m_addr = a;
            m_mask = ~bwn;
            m_op = (!cs[0] && cs[1] && !cs[2]) ? (wen ? 2'd1 : 2'd2) : 2'd0;
         end
      end
      chk_out();
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d);
      go(1'b0, 1'b0, 1'b0, 1'b1, SEL, a, '0, d);
   endtask
   task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bwn, input logic [DW-1:0] d);
      go(1'b0, 1'b0, 1'b0, 1'b0, SEL, a, bwn, d);
   endtask
   task automatic des(input logic [DW-1:0] d);
      go(1'b0, 1'b0, 1'b0, 1'b1, 3'b011, '0, '0, d);
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int k);
      return DW'((a * 16'h1357) ^ (k * 16'h0F21) ^ 16'hA5A5);
   endfunction

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R12: reset state
      repeat (3) @(posedge clk);
      #1 check("R12", {dout_en, dout}, '0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 check("R12", {dout_en, dout}, '0);

      // R3: fill back to back; din on the address edge is junk
      cur_req = "R3";
      wr(0, 2'b00, 16'hDEAD);
      for (int a = 1; a < DEPTH; a++) wr(AW'(a), 2'b00, pat(a - 1, 0));
      rd(0, pat(DEPTH - 1, 0));
      cur_req = "R2";
      for (int a = 1; a < DEPTH; a++) rd(AW'(a), 16'hBEEF);

      // R4 / R5: every address and byte mask, write then read at once
      cur_req = "R4_R5";
      for (int a = 0; a < DEPTH; a++)
         for (int m = 0; m < 4; m++) begin
            wr(AW'(a), NL'(m), 16'h5A5A);
            rd(AW'(a), pat(a, m + 1));
         end
      // R5: write, write, read, read interleaved
      cur_req = "R5";
      for (int a = 0; a < DEPTH - 1; a++) begin
         wr(AW'(a), 2'b01, 16'h0);
         wr(AW'(a + 1), 2'b10, pat(a, 7));
         rd(AW'(a), pat(a + 1, 8));
         rd(AW'(a + 1), 16'h0);
         wr(AW'(a), 2'b00, 16'h0);
         rd(AW'(a), pat(a, 9));
      end

      // R1: all chip-enable combinations for reads and writes
      cur_req = "R1";
      for (int c = 0; c < 8; c++) go(1'b0, 1'b0, 1'b0, 1'b1, 3'(c), AW'(c), '0, 16'h0);
      for (int c = 0; c < 8; c++) begin
         go(1'b0, 1'b0, 1'b0, 1'b0, 3'(c), 4'd9, 2'b00, 16'h0);
         rd(4'd9, pat(c, 11));
      end

      // R9: write data period with oe_n low stays quiet
      cur_req = "R9";
      wr(4'd3, 2'b00, 16'h0);
      des(pat(3, 12));
      des(16'h0);

      // R11: pending write survives reads and deselects
      cur_req = "R11";
      wr(4'd5, 2'b10, 16'h0);
      rd(4'd6, pat(5, 13));
      rd(4'd7, 16'h0);
      des(16'h0);
      des(16'h0);
      rd(4'd5, 16'h0);

      // R6: strobe high repeats the last read, then the last write
      cur_req = "R6";
      rd(4'd2, 16'h0);
      go(1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 4'd11, 2'b11, 16'h0);
      wr(4'd8, 2'b01, 16'h0);
      go(1'b0, 1'b0, 1'b1, 1'b1, 3'b001, 4'd12, 2'b10, pat(8, 14));
      rd(4'd8, pat(8, 15));

      // R7: suspended edges ignore a new read and a write's data
      cur_req = "R7";
      rd(4'd4, 16'h0);
      go(1'b1, 1'b0, 1'b0, 1'b1, SEL, 4'd10, '0, 16'h0);
      wr(4'd10, 2'b00, 16'h0);
      go(1'b1, 1'b0, 1'b0, 1'b1, SEL, 4'd1, '0, 16'hFFFF);
      rd(4'd10, pat(10, 16));
      rd(4'd10, 16'h0);

      // R8: output enable gates the bus without a clock edge
      cur_req = "R8";
      oe_n = 1'b1;
      rd(4'd2, 16'h0);
      oe_n = 1'b0;
      #0.5 chk_out();
      oe_n = 1'b1;
      #0.5 chk_out();
      oe_n = 1'b0;

      // R10: snooze blocks new cycles and keeps contents
      cur_req = "R10";
      go(1'b0, 1'b1, 1'b0, 1'b1, SEL, 4'd3, '0, 16'h0);
      go(1'b0, 1'b1, 1'b0, 1'b0, SEL, 4'd3, 2'b00, 16'h0);
      go(1'b0, 1'b1, 1'b0, 1'b1, SEL, 4'd3, '0, 16'h1234);
      rd(4'd3, 16'h0);
      for (int a = 0; a < DEPTH; a++) rd(AW'(a), 16'h0);
      des(16'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule